// File: doc/BRIEF.md
# Two-Dimensional DMA Address Walker

This block drives the address side of one DMA channel. A 128-bit transfer control block (TCB) is written through a load port. The TCB packs four 32-bit words: a start address, an X count/modify pair, a Y count/modify pair and a control word. Once a valid TCB is accepted, the block raises one request per transfer. Each request carries an address and an operand size, and stays up until the memory or bus side grants it. After the last grant the block pulses `done` and returns to idle, ready for the next TCB.

Counts and modifies are always measured in 32-bit words, whatever the operand size. A long operand therefore uses up two words of count and a quad operand uses up four, and addresses are word addresses. In two-dimensional mode the X pair walks the words within one row. The Y pair gives the jump taken at the end of each row and the number of rows. In one-dimensional mode the Y word is never looked at.

Top module: `dma_addr_gen`

## Requirements
- R1: A TCB is accepted on a clock edge where `tcbValid` is high and the block is idle, which `tcbReady` shows. Bits 31:0 hold the start address, 63:48 the X count, 47:32 the X modify, 95:80 the Y count, 79:64 the Y modify and 99:96 the control field. Other bits are ignored.
- R2: The first request after an accepted, enabled and valid TCB carries the start address. Its `reqSize` equals control bits 1:0, where 00 is a 32-bit operand, 01 is 64-bit and 10 is 128-bit.
- R3: While `reqValid` is high and `reqGrant` is low, `reqValid` stays high and `reqAddr` does not change.
- R4: In one-dimensional mode (control bit 2 clear), each grant moves the address by the X modify, sign-extended from 16 bits.
- R5: Each grant uses up 1, 2 or 4 words of X count for 32, 64 or 128-bit operands. A one-dimensional run therefore issues X count divided by words-per-operand requests.
- R6: In two-dimensional mode (control bit 2 set), the grant that uses up the X count moves the address by the sign-extended Y modify instead of the X modify. That grant also reloads the X count and takes one from the Y count. The run ends after Y count rows.
- R7: In one-dimensional mode the Y word has no effect, and a zero Y count is not an error.
- R8: `done` is high for exactly the one cycle after the last grant. In that cycle `reqValid` is low and `tcbReady` is high.
- R9: An enabled TCB is rejected, with `loadErr` set and no request issued, in any of these cases: a zero X count, an X count that is not a multiple of the words-per-operand, operand code 11, or two-dimensional mode with a zero Y count. `loadErr` holds until the next accepted TCB clears or sets it again.
- R10: A TCB with control bit 3 (enable) clear is accepted but starts nothing: no request, no `done` and no `loadErr`.
- R11: While a run is active, `tcbReady` is low and `tcbValid` is ignored. The ongoing address walk is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tcbValid | input | 1 | TCB write strobe |
| tcbData | input | 128 | Transfer control block |
| tcbReady | output | 1 | Channel idle, TCB can be accepted |
| reqValid | output | 1 | Transfer request |
| reqAddr | output | 32 | Word address of the current transfer |
| reqSize | output | 2 | Operand size code of the current transfer |
| reqGrant | input | 1 | Grant for the current request |
| done | output | 1 | One-cycle pulse after the final grant |
| loadErr | output | 1 | Last accepted TCB was rejected |

## Verification
The bench builds the block with its default 32-bit word width, which gives a 128-bit TCB and 16-bit count and modify fields. With these widths, a negative modify such as 0xFFFE walks addresses downward, so the sign extension is exercised. The same width lets every operand size be checked against counts that divide evenly and counts that do not. The bench also inserts grant stalls on alternate transfers, so the hold behaviour of each request is observed in both one- and two-dimensional walks.

// File: rtl/dmaAgPkg.sv
package dmaAgPkg;
  typedef enum logic [1:0] {
    OP_WORD = 2'b00,
    OP_LONG = 2'b01,
    OP_QUAD = 2'b10,
    OP_RSVD = 2'b11
  } opLenE;

  typedef struct packed {
    logic load;
    logic advance;
  } agStrobeT;

  typedef struct packed {
    logic cfgBad;
    logic cfgOn;
    logic xLast;
    logic yLast;
    logic twoD;
  } agStatusT;
endpackage

// File: rtl/dma_ag_path.sv
module dma_ag_path
  import dmaAgPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  agStrobeT              strobe,
  input  logic [4*WORD_W-1:0]   tcbData,
  output agStatusT              status,
  output logic [WORD_W-1:0]     addr,
  output logic [1:0]            opLen
);
  localparam int CNT_W = WORD_W / 2;
  localparam int EXT_W = WORD_W - CNT_W;

  // fields of the incoming TCB
  logic [WORD_W-1:0] ldIdx;
  logic [CNT_W-1:0]  ldXCnt, ldXMod, ldYCnt, ldYMod;
  logic [3:0]        ldCtl;

  assign ldIdx  = tcbData[WORD_W-1:0];
  assign ldXMod = tcbData[WORD_W +: CNT_W];
  assign ldXCnt = tcbData[WORD_W+CNT_W +: CNT_W];
  assign ldYMod = tcbData[2*WORD_W +: CNT_W];
  assign ldYCnt = tcbData[2*WORD_W+CNT_W +: CNT_W];
  assign ldCtl  = tcbData[3*WORD_W +: 4];

  function automatic logic [CNT_W-1:0] wordsPer(input logic [1:0] op);
    case (op)
      OP_LONG: wordsPer = CNT_W'(2);
      OP_QUAD: wordsPer = CNT_W'(4);
      default: wordsPer = CNT_W'(1);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] sext(input logic [CNT_W-1:0] m);
    sext = {{EXT_W{m[CNT_W-1]}}, m};
  endfunction

  // load-time validity check
  logic badCnt, badSize, badY;
  always_comb begin
    badSize = (ldCtl[1:0] == OP_RSVD);
    badY    = ldCtl[2] && (ldYCnt == '0);
    case (ldCtl[1:0])
      OP_LONG: badCnt = (ldXCnt == '0) || ldXCnt[0];
      OP_QUAD: badCnt = (ldXCnt == '0) || (ldXCnt[1:0] != 2'b00);
      default: badCnt = (ldXCnt == '0);
    endcase
  end

  // working state
  logic [WORD_W-1:0] addrQ;
  logic [CNT_W-1:0]  xRemQ, yRemQ, xCntQ, xModQ, yModQ;
  logic [1:0]        opQ;
  logic              twoDQ;
  logic [CNT_W-1:0]  stepWords;

  assign stepWords = wordsPer(opQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      xRemQ <= '0;
      yRemQ <= '0;
      xCntQ <= '0;
      xModQ <= '0;
      yModQ <= '0;
      opQ   <= OP_WORD;
      twoDQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ <= ldIdx;
      xRemQ <= ldXCnt;
      xCntQ <= ldXCnt;
      xModQ <= ldXMod;
      yRemQ <= ldYCnt;
      yModQ <= ldYMod;
      opQ   <= ldCtl[1:0];
      twoDQ <= ldCtl[2];
    end else if (strobe.advance) begin
      if (status.xLast && twoDQ) begin
        addrQ <= addrQ + sext(yModQ);
        xRemQ <= xCntQ;
        yRemQ <= yRemQ - CNT_W'(1);
      end else begin
        addrQ <= addrQ + sext(xModQ);
        xRemQ <= xRemQ - stepWords;
      end
    end
  end

  assign status.cfgBad = badCnt || badSize || badY;
  assign status.cfgOn  = ldCtl[3];
  assign status.xLast  = (xRemQ == stepWords);
  assign status.yLast  = (yRemQ == CNT_W'(1));
  assign status.twoD   = twoDQ;
  assign addr          = addrQ;
  assign opLen         = opQ;

  // R5: a granted step never consumes more words than remain
  p_step_fits_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (xRemQ >= stepWords));

  // R6: a granted step in 2D mode always has a row left
  p_row_left_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && twoDQ) |-> (yRemQ != '0));
endmodule

// File: rtl/dma_ag_ctrl.sv
module dma_ag_ctrl
  import dmaAgPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tcbValid,
  input  logic     reqGrant,
  input  agStatusT status,
  output agStrobeT strobe,
  output logic     tcbReady,
  output logic     reqValid,
  output logic     done,
  output logic     loadErr
);
  typedef enum logic {S_IDLE, S_RUN} stateE;
  stateE stateQ;

  logic accept, finish;

  assign accept         = tcbValid && (stateQ == S_IDLE);
  assign strobe.load    = accept;
  assign strobe.advance = (stateQ == S_RUN) && reqGrant;
  assign finish         = strobe.advance && status.xLast &&
                          (!status.twoD || status.yLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      done    <= 1'b0;
      loadErr <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        loadErr <= status.cfgOn && status.cfgBad;
        if (status.cfgOn && !status.cfgBad) stateQ <= S_RUN;
      end else if (finish) begin
        stateQ <= S_IDLE;
      end
    end
  end

  assign tcbReady = (stateQ == S_IDLE);
  assign reqValid = (stateQ == S_RUN);

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done comes only straight after a grant
  p_done_after_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(reqValid && reqGrant));

  // R9: a rejected TCB never produces a request
  p_err_no_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadErr |-> !reqValid);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dmaAgPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tcbValid,
  input  logic [4*WORD_W-1:0] tcbData,
  output logic                tcbReady,
  output logic                reqValid,
  output logic [WORD_W-1:0]   reqAddr,
  output logic [1:0]          reqSize,
  input  logic                reqGrant,
  output logic                done,
  output logic                loadErr
);
  agStrobeT strobe;
  agStatusT status;

  dma_ag_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tcbValid (tcbValid),
    .reqGrant (reqGrant),
    .status   (status),
    .strobe   (strobe),
    .tcbReady (tcbReady),
    .reqValid (reqValid),
    .done     (done),
    .loadErr  (loadErr)
  );

  dma_ag_path #(.WORD_W(WORD_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .tcbData (tcbData),
    .status  (status),
    .addr    (reqAddr),
    .opLen   (reqSize)
  );

  // R3: an ungranted request holds its address
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqGrant) |=> (reqValid && $stable(reqAddr) && $stable(reqSize)));
endmodule

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
  typedef struct packed {
    logic [31:0] idx;
    logic [15:0] xc;
    logic [15:0] xm;
    logic [15:0] yc;
    logic [15:0] ym;
    logic [3:0]  ctl;
    logic        err;
  } vecT;

  localparam int NV = 11;
  localparam vecT VECS [NV] = '{
    '{32'h0000_0100, 16'd4,  16'h0001, 16'd0, 16'h0000, 4'b1000, 1'b0}, // 1D word
    '{32'h0000_0400, 16'h10, 16'h0004, 16'd0, 16'h0000, 4'b1010, 1'b0}, // 1D quad
    '{32'h0000_0200, 16'd6,  16'hFFFE, 16'd0, 16'h0000, 4'b1001, 1'b0}, // 1D long, negative
    '{32'h0000_0000, 16'd3,  16'h0001, 16'd2, 16'h0010, 4'b1100, 1'b0}, // 2D word
    '{32'h0000_1000, 16'd4,  16'h0002, 16'd3, 16'hFFF8, 4'b1101, 1'b0}, // 2D long, negative Y
    '{32'h0000_0000, 16'd0,  16'h0001, 16'd0, 16'h0000, 4'b1000, 1'b1}, // zero count
    '{32'h0000_0000, 16'd6,  16'h0004, 16'd0, 16'h0000, 4'b1010, 1'b1}, // quad, not multiple
    '{32'h0000_0000, 16'd4,  16'h0001, 16'd0, 16'h0000, 4'b1100, 1'b1}, // 2D, zero Y
    '{32'h0000_0000, 16'd4,  16'h0001, 16'd1, 16'h0000, 4'b1011, 1'b1}, // reserved size
    '{32'h0000_0300, 16'd2,  16'h0003, 16'd0, 16'h0777, 4'b1000, 1'b0}, // 1D, Y junk
    '{32'h0000_0500, 16'd4,  16'h0001, 16'd2, 16'h0000, 4'b0100, 1'b0}  // disabled
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tcbValid = 1'b0;
  logic [127:0] tcbData = '0;
  logic         reqGrant = 1'b0;
  logic         tcbReady, reqValid, done, loadErr;
  logic [31:0]  reqAddr;
  logic [1:0]   reqSize;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_addr_gen u0 (
    .clk(clk), .rstN(rstN), .tcbValid(tcbValid), .tcbData(tcbData),
    .tcbReady(tcbReady), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqGrant(reqGrant), .done(done), .loadErr(loadErr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] pack(input vecT v);
    pack = '0;
    pack[31:0]   = v.idx;
    pack[63:48]  = v.xc;
    pack[47:32]  = v.xm;
    pack[95:80]  = v.yc;
    pack[79:64]  = v.ym;
    pack[99:96]  = v.ctl;
    pack[127:100] = 28'hABCDEF1; // reserved bits, must be ignored
    return pack;
  endfunction

  task automatic loadTcb(input vecT v);
    @(negedge clk);
    tcbData  = pack(v);
    tcbValid = 1'b1;
    @(negedge clk);
    tcbValid = 1'b0;
  endtask

  // walk a loaded vector, optionally probe a busy reload at the first request
  task automatic runVec(input vecT v, input bit probeBusy);
    int sz = (v.ctl[1:0] == 2'b00) ? 1 : (v.ctl[1:0] == 2'b01) ? 2 : 4;
    bit twoD = v.ctl[2];
    int total = twoD ? (int'(v.yc) * (int'(v.xc) / sz)) : (int'(v.xc) / sz);
    logic [31:0] a = v.idx;
    int xr = int'(v.xc);
    int yr = int'(v.yc);
    vecT junk = '{32'hDEAD_0000, 16'd8, 16'h0001, 16'd0, 16'h0, 4'b1000, 1'b0};
    loadTcb(v);
    if (!v.ctl[3]) begin
      for (int i = 0; i < 3; i++) begin
        chk(!reqValid && !done && !loadErr, "R10 disabled TCB idle", {29'b0, reqValid, done, loadErr}, 32'h0);
        @(negedge clk);
      end
      return;
    end
    if (v.err) begin
      chk(loadErr === 1'b1, "R9 loadErr set", 32'(loadErr), 32'h1);
      chk(!reqValid, "R9 no request", 32'(reqValid), 32'h0);
      @(negedge clk);
      chk(!reqValid && loadErr && tcbReady, "R9 stays rejected", {29'b0, reqValid, loadErr, tcbReady}, 32'h3);
      return;
    end
    chk(!loadErr, "R9 loadErr clear on good TCB", 32'(loadErr), 32'h0);
    if (probeBusy) begin
      chk(!tcbReady, "R11 not ready while busy", 32'(tcbReady), 32'h0);
      tcbData = pack(junk);
      tcbValid = 1'b1;
      @(negedge clk);
      tcbValid = 1'b0;
    end
    for (int n = 0; n < total; n++) begin
      chk(reqValid === 1'b1, "R2 request raised", 32'(reqValid), 32'h1);
      chk(reqAddr === a, twoD ? "R6 2D address" : (n == 0 ? "R2 start address" : "R4 1D address"), reqAddr, a);
      chk(reqSize === v.ctl[1:0], "R2 size code", 32'(reqSize), 32'(v.ctl[1:0]));
      if (n % 2 == 1) begin
        @(negedge clk);
        chk(reqValid && reqAddr === a, "R3 held during stall", reqAddr, a);
      end
      reqGrant = 1'b1;
      @(negedge clk);
      reqGrant = 1'b0;
      if (twoD && xr == sz) begin
        a = a + {{16{v.ym[15]}}, v.ym};
        xr = int'(v.xc);
        yr--;
      end else begin
        a = a + {{16{v.xm[15]}}, v.xm};
        xr -= sz;
      end
      if (n < total - 1)
        chk(!done, "R5 no early done", 32'(done), 32'h0);
    end
    chk(done === 1'b1, "R8 done after last grant", 32'(done), 32'h1);
    chk(!reqValid && tcbReady, "R8 idle with done", {30'b0, reqValid, tcbReady}, 32'h1);
    @(negedge clk);
    chk(!done, "R8 done one cycle", 32'(done), 32'h0);
    chk(!reqValid, "R5 no extra request", 32'(reqValid), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!reqValid && tcbReady && !done && !loadErr, "R1 reset state",
        {28'b0, reqValid, tcbReady, done, loadErr}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) runVec(VECS[i], 1'b0);
    // R11: reload attempted during an active run
    runVec(VECS[0], 1'b1);
    // R9: error then good load clears the flag
    runVec(VECS[5], 1'b0);
    runVec(VECS[2], 1'b0);
    // R7: 1D with zero Y count and nonzero Y modify runs normally
    runVec(VECS[9], 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule